// File: doc/BRIEF.md
# Sectored Four-Way Read Cache Controller

This block is a read cache placed between a 32-bit processor request port and a slower external memory port. Its data store is 1 KB. The store is organised as four ways. Each way has four frames, each frame has four lines, and each line holds four 32-bit words. Each frame carries one tag. Each line carries its own valid bit, so a frame fills one line at a time. Tags, valid bits and the replacement order are registers inside the block.

A read that hits returns the stored word. A read that misses fetches exactly one line from external memory, word by word, and then answers with the requested word. The replacement order is a true least-recently-used order of the four ways, kept for each frame index. A processor write is always forwarded to memory, and it invalidates the matching line if that line is present. A plain enable input turns caching off, and every read then goes straight to memory.

Both ports use valid/ready handshakes:
- **Request port:** a request is taken in the cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is high only while no access is in progress.
- **Response port:** a read response stays on `cpu_rsp_data`, with `cpu_rsp_valid` high and the data unchanged, until `cpu_rsp_ready` is seen high.
- **Memory port:** once `mem_req_valid` is raised, the block holds it and keeps the address, direction and write data stable until `mem_req_ready`. For a read, `mem_rsp_data` is taken in the cycle where `mem_req_valid` and `mem_req_ready` are both high.
- **Writes:** a write produces no response.

Top module: `sc_cache`

## Requirements
- R1: After reset all lines are invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0. The first read of any address after a reset therefore misses.
- R2: Address fields are decoded as follows: word within line is addr[3:2], line within frame is addr[5:4], frame index is addr[7:6] and tag is addr[25:8]. A read whose tag matches a frame and whose line is valid returns the stored word. It makes no memory request, and `cpu_rsp_valid` rises in the second cycle after the request is accepted.
- R3: A read whose tag matches no frame at its index fetches one line with exactly four memory reads, at addresses line base +0, +4, +8 and +12. The response comes only after the fourth read and carries the requested word.
- R4: A read whose tag matches a frame but whose line is invalid fetches only that line into the same frame. The other valid lines of that frame keep hitting afterwards.
- R5: On a full miss the victim is the least recently used way at that index, where every hit and every fill counts as a use. Replacing a frame invalidates all its lines, so the other lines of the new tag miss.
- R6: Frame indices are independent: fills and hits at one index do not change the contents or the replacement order of another index.
- R7: A write is forwarded as exactly one memory write with the request's address and data, and it produces no response. A write to an address not present does not allocate.
- R8: A write to a valid present line invalidates only that line. The next read of it refetches the line, and the frame's other lines still hit.
- R9: With `cache_en` low, a read makes exactly one memory read at its word address and returns that data. The cache contents are kept, so after re-enabling, earlier lines still hit.
- R10: While `cpu_rsp_ready` is low, `cpu_rsp_valid` stays high with stable data and no new request is accepted. While `mem_req_ready` is low, the memory request stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 enables caching, 0 bypasses reads to memory |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can take a request |
| cpu_req_write | input | 1 | 1 write, 0 read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | Read data valid |
| cpu_rsp_ready | input | 1 | Processor takes read data |
| cpu_rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request (read data returned same cycle) |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word-aligned memory address (writes pass the request address) |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_data | input | 32 | Read data, valid with the read handshake |

## Verification
A wrong internal state shows up at the ports within a single access, as the count of memory reads that the access causes:
- **Stale valid bit:** it turns an expected four-word fetch into a hit with no memory reads and wrong data.
- **Lost valid bit:** it causes a refetch where a hit was due.
- **Wrong replacement order:** it is seen one access later, when the line that should have survived misses and the one that should have left hits.
- **Fetch counter or address error:** the fill addresses and the returned word are compared on every miss, so these show up on the same access.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_BYP,
    ST_WR,
    ST_RESP
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int LINES = 4,
  parameter int TAG_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [$clog2(LINES)-1:0] lk_line,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic [WAYS-1:0]          frame_hit,
  output logic [WAYS-1:0]          line_ok,
  input  logic                     alloc_en,
  input  logic                     setv_en,
  input  logic                     clrv_en,
  input  logic [$clog2(WAYS)-1:0]  upd_way,
  input  logic [$clog2(SETS)-1:0]  upd_set,
  input  logic [$clog2(LINES)-1:0] upd_line
);
  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [LINES-1:0] vld_q [WAYS][SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign frame_hit[w] = (|vld_q[w][lk_set]) && (tag_q[w][lk_set] == lk_tag);
    assign line_ok[w]   = vld_q[w][lk_set][lk_line];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[w][s] <= '0;
          vld_q[w][s] <= '0;
        end
      end
    end else if (alloc_en) begin
      tag_q[upd_way][upd_set] <= lk_tag;
      vld_q[upd_way][upd_set] <= '0;
    end else if (setv_en) begin
      vld_q[upd_way][upd_set][upd_line] <= 1'b1;
    end else if (clrv_en) begin
      vld_q[upd_way][upd_set][upd_line] <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_lru.sv
module sc_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] set_i,
  output logic [$clog2(WAYS)-1:0] victim_o,
  input  logic                    touch_en,
  input  logic [$clog2(WAYS)-1:0] touch_way
);
  localparam int AW = $clog2(WAYS);
  localparam logic [AW-1:0] OLDEST = AW'(WAYS - 1);

  logic [AW-1:0] age_q [SETS][WAYS];

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[set_i][w] == OLDEST) victim_o = AW'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= AW'(WAYS - 1 - w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AW'(w) == touch_way)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_data_ram.sv
module sc_data_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sc_cache.sv
module sc_cache #(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int LINES = 4,
  parameter int WORDS = 4,
  parameter int TAG_W = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cache_en,
  input  logic        cpu_req_valid,
  output logic        cpu_req_ready,
  input  logic        cpu_req_write,
  input  logic [31:0] cpu_req_addr,
  input  logic [31:0] cpu_req_wdata,
  output logic        cpu_rsp_valid,
  input  logic        cpu_rsp_ready,
  output logic [31:0] cpu_rsp_data,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic [31:0] mem_rsp_data
);
  import sc_pkg::*;

  localparam int WW      = $clog2(WAYS);
  localparam int SW      = $clog2(SETS);
  localparam int LW      = $clog2(LINES);
  localparam int OW      = $clog2(WORDS);
  localparam int LINE_LO = 2 + OW;
  localparam int SET_LO  = LINE_LO + LW;
  localparam int TAG_LO  = SET_LO + SW;
  localparam int DEPTH   = WAYS * SETS * LINES * WORDS;
  localparam int IW      = WW + SW + LW + OW;
  localparam logic [OW-1:0] LAST_WORD = OW'(WORDS - 1);

  sc_state_e state_q;
  logic [31:0] addr_q, wdata_q, rsp_q;
  logic [WW-1:0] way_q;
  logic [OW-1:0] cnt_q;

  logic [OW-1:0]    f_word;
  logic [LW-1:0]    f_line;
  logic [SW-1:0]    f_set;
  logic [TAG_W-1:0] f_tag;
  assign f_word = addr_q[2 +: OW];
  assign f_line = addr_q[LINE_LO +: LW];
  assign f_set  = addr_q[SET_LO +: SW];
  assign f_tag  = addr_q[TAG_LO +: TAG_W];

  logic [WAYS-1:0] frame_hit, line_ok;
  logic            any_hit, hit_line;
  logic [WW-1:0]   hit_way, victim;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (frame_hit[w]) hit_way = WW'(w);
    end
  end
  assign any_hit  = |frame_hit;
  assign hit_line = any_hit && line_ok[hit_way];

  logic fill_hs;
  assign fill_hs = (state_q == ST_FILL) && mem_req_ready;

  logic alloc_en, setv_en, clrv_en, touch_en;
  logic [WW-1:0] upd_way;
  always_comb begin
    alloc_en = 1'b0;
    clrv_en  = 1'b0;
    touch_en = 1'b0;
    setv_en  = fill_hs && (cnt_q == LAST_WORD);
    upd_way  = way_q;
    if (state_q == ST_LOOK) begin
      upd_way = any_hit ? hit_way : victim;
      if (addr_q_write()) begin
        clrv_en = hit_line;
      end else if (cache_en) begin
        touch_en = hit_line;
        alloc_en = !any_hit;
      end
    end else if (setv_en) begin
      touch_en = 1'b1;
    end
  end

  logic wr_q;
  function automatic logic addr_q_write();
    return wr_q;
  endfunction

  sc_tag_store #(.WAYS(WAYS), .SETS(SETS), .LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_set    (f_set),
    .lk_line   (f_line),
    .lk_tag    (f_tag),
    .frame_hit (frame_hit),
    .line_ok   (line_ok),
    .alloc_en  (alloc_en),
    .setv_en   (setv_en),
    .clrv_en   (clrv_en),
    .upd_way   (upd_way),
    .upd_set   (f_set),
    .upd_line  (f_line)
  );

  sc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (f_set),
    .victim_o  (victim),
    .touch_en  (touch_en),
    .touch_way (upd_way)
  );

  logic [IW-1:0] ram_raddr, ram_waddr;
  logic [31:0]   ram_rdata;
  assign ram_raddr = {hit_way, f_set, f_line, f_word};
  assign ram_waddr = {way_q, f_set, f_line, cnt_q};

  sc_data_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk   (clk),
    .we    (fill_hs),
    .waddr (ram_waddr),
    .wdata (mem_rsp_data),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rsp_q   <= '0;
      way_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            wr_q    <= cpu_req_write;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          cnt_q <= '0;
          if (wr_q) begin
            state_q <= ST_WR;
          end else if (!cache_en) begin
            state_q <= ST_BYP;
          end else if (hit_line) begin
            rsp_q   <= ram_rdata;
            state_q <= ST_RESP;
          end else begin
            way_q   <= any_hit ? hit_way : victim;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_req_ready) begin
            if (cnt_q == f_word) rsp_q <= mem_rsp_data;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_WORD) state_q <= ST_RESP;
          end
        end
        ST_BYP: begin
          if (mem_req_ready) begin
            rsp_q   <= mem_rsp_data;
            state_q <= ST_RESP;
          end
        end
        ST_WR: begin
          if (mem_req_ready) state_q <= ST_IDLE;
        end
        ST_RESP: begin
          if (cpu_rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rsp_data  = rsp_q;
  assign mem_req_valid = (state_q == ST_FILL) || (state_q == ST_BYP) || (state_q == ST_WR);
  assign mem_req_write = (state_q == ST_WR);
  assign mem_req_wdata = wdata_q;

  always_comb begin
    unique case (state_q)
      ST_FILL: mem_req_addr = {addr_q[31:LINE_LO], cnt_q, 2'b00};
      ST_BYP:  mem_req_addr = {addr_q[31:2], 2'b00};
      default: mem_req_addr = addr_q;
    endcase
  end
endmodule

// File: rtl/sc_cache_chk.sv
module sc_cache_chk #(
  parameter int WORDS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req_valid,
  input logic        cpu_req_ready,
  input logic        cpu_rsp_valid,
  input logic        cpu_rsp_ready,
  input logic [31:0] cpu_rsp_data,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic [31:0] mem_req_wdata
);
  logic [7:0]  rd_cnt, wr_cnt;
  logic [31:0] prev_addr;
  logic        rd_hs, wr_hs, acc;
  assign rd_hs = mem_req_valid && mem_req_ready && !mem_req_write;
  assign wr_hs = mem_req_valid && mem_req_ready && mem_req_write;
  assign acc   = cpu_req_valid && cpu_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      prev_addr <= '0;
    end else begin
      if (acc) begin
        rd_cnt <= '0;
        wr_cnt <= '0;
      end else begin
        if (rd_hs) rd_cnt <= rd_cnt + 1'b1;
        if (wr_hs) wr_cnt <= wr_cnt + 1'b1;
      end
      if (rd_hs) prev_addr <= mem_req_addr;
    end
  end

  // R1, R10: one access at a time
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> (!cpu_rsp_valid && !mem_req_valid));

  // R3: a response follows zero, one or a whole line of reads
  a_r3_line_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rsp_valid) |-> (rd_cnt == 8'd0 || rd_cnt == 8'd1 || rd_cnt == 8'(WORDS)));

  // R3: consecutive reads of one fill step by one word
  a_r3_seq_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && rd_cnt != 8'd0) |-> (mem_req_addr == prev_addr + 32'd4));

  // R7: a write goes out once
  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hs |-> (wr_cnt == 8'd0 && rd_cnt == 8'd0));

  // R10: response held under back-pressure
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_data)));

  // R10: memory request held until accepted
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
endmodule

bind sc_cache sc_cache_chk #(.WORDS(WORDS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_ready (cpu_rsp_ready),
  .cpu_rsp_data  (cpu_rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/sc_cache_tb.sv
module sc_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cache_en = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic cpu_rsp_ready = 1'b1;
  logic [31:0] cpu_rsp_data;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;

  always #4 clk = ~clk;

  sc_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_data(cpu_rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'hC3C3};
  endfunction
  assign mem_rsp_data = memf(mem_req_addr);

  function automatic logic [31:0] ad(input int tg, input int ix, input int ln, input int wd);
    return (32'(tg) << 8) | (32'(ix) << 6) | (32'(ln) << 4) | (32'(wd) << 2);
  endfunction

  // {req number, write, address, expected memory transfers}
  function automatic logic [39:0] mk(input int rq, input bit wr, input int tg, input int ix,
                                     input int ln, input int wd, input int ex);
    return {4'(rq), wr, ad(tg, ix, ln, wd), 3'(ex)};
  endfunction

  localparam int NV = 22;
  localparam logic [39:0] VEC [NV] = '{
    mk(3, 0, 1, 0, 0, 1, 4),  // R3 cold miss
    mk(2, 0, 1, 0, 0, 3, 0),  // R2 hit other word
    mk(4, 0, 1, 0, 2, 0, 4),  // R4 sector fill
    mk(4, 0, 1, 0, 0, 0, 0),  // R4 first line kept
    mk(2, 0, 1, 0, 2, 2, 0),
    mk(3, 0, 2, 0, 0, 0, 4),
    mk(3, 0, 3, 0, 0, 0, 4),
    mk(3, 0, 4, 0, 0, 0, 4),
    mk(4, 0, 1, 0, 1, 0, 4),  // R4 fill makes tag 1 most recent
    mk(5, 0, 5, 0, 0, 0, 4),  // R5 evicts tag 2
    mk(5, 0, 1, 0, 0, 0, 0),  // R5 tag 1 survived
    mk(5, 0, 2, 0, 0, 0, 4),
    mk(5, 0, 3, 0, 0, 0, 4),
    mk(5, 0, 4, 0, 0, 0, 4),
    mk(2, 0, 1, 0, 2, 0, 0),
    mk(6, 0, 1, 1, 0, 0, 4),  // R6 other index
    mk(6, 0, 2, 0, 0, 0, 0),  // R6 index 0 untouched
    mk(7, 1, 1, 0, 2, 1, 1),  // R7 write hit
    mk(8, 0, 1, 0, 2, 0, 4),  // R8 refetch
    mk(8, 0, 1, 0, 0, 0, 0),  // R8 neighbour line kept
    mk(7, 1, 6, 0, 0, 0, 1),  // R7 write miss
    mk(8, 0, 3, 0, 0, 0, 0)   // R7 R8 no allocation
  };

  int n_chk = 0, n_bad = 0;
  int rd_tot = 0, wr_tot = 0;
  logic [31:0] rd_log [64];
  logic [31:0] wr_a, wr_d;
  logic stall = 1'b0;
  int phase = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_tot <= wr_tot + 1;
        wr_a   <= mem_req_addr;
        wr_d   <= mem_req_wdata;
      end else begin
        rd_log[rd_tot % 64] <= mem_req_addr;
        rd_tot <= rd_tot + 1;
      end
    end
  end

  always @(negedge clk) begin
    phase <= (phase + 1) % 3;
    mem_req_ready <= stall ? (phase != 0) : 1'b1;
  end

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run(input int rqn, input logic wr, input logic [31:0] a, input logic [31:0] d,
                     input int exp_n);
    int rd0, wr0, lat;
    string rq;
    logic saw_rsp;
    rq = $sformatf("R%0d", rqn);
    @(negedge clk);
    while (!cpu_req_ready) @(negedge clk);
    rd0 = rd_tot;
    wr0 = wr_tot;
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (!wr) begin
      lat = 1;
      while (!cpu_rsp_valid) begin
        @(negedge clk);
        lat++;
      end
      check(rq, "memory reads", 32'(rd_tot - rd0), 32'(exp_n));
      check(rq, "read data", cpu_rsp_data, memf({a[31:2], 2'b00}));
      if (exp_n == 0) check(rq, "hit latency", 32'(lat), 32'd2);
      if (exp_n == 4) begin
        for (int k = 0; k < 4; k++)
          check(rq, "fill address", rd_log[(rd0 + k) % 64], {a[31:4], 2'(k), 2'b00});
      end
      if (exp_n == 1) check(rq, "bypass address", rd_log[rd0 % 64], {a[31:2], 2'b00});
      @(negedge clk);
    end else begin
      saw_rsp = 1'b0;
      while (!cpu_req_ready) begin
        if (cpu_rsp_valid) saw_rsp = 1'b1;
        @(negedge clk);
      end
      check(rq, "write count", 32'(wr_tot - wr0), 32'd1);
      check(rq, "write address", wr_a, a);
      check(rq, "write data", wr_d, d);
      check(rq, "reads on write", 32'(rd_tot - rd0), 32'd0);
      check(rq, "write response", 32'(saw_rsp), 32'd0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "req ready after reset", 32'(cpu_req_ready), 32'd1);
    check("R1", "rsp valid after reset", 32'(cpu_rsp_valid), 32'd0);
    check("R1", "mem valid after reset", 32'(mem_req_valid), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    int rd0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      stall = (i >= 11);
      run(int'(VEC[i][39:36]), VEC[i][35], VEC[i][34:3], 32'hD000_0000 | 32'(i), int'(VEC[i][2:0]));
    end
    stall = 1'b0;

    // R9: bypass while disabled, contents kept
    cache_en = 1'b0;
    run(9, 1'b0, ad(1, 0, 0, 2), 32'h0, 1);
    cache_en = 1'b1;
    run(9, 1'b0, ad(1, 0, 0, 2), 32'h0, 0);

    // R10: response back-pressure
    cpu_rsp_ready = 1'b0;
    @(negedge clk);
    rd0 = rd_tot;
    cpu_req_valid = 1'b1;
    cpu_req_write = 1'b0;
    cpu_req_addr  = ad(3, 0, 0, 1);
    @(negedge clk);
    while (!cpu_rsp_valid) @(negedge clk);
    held = cpu_rsp_data;
    repeat (5) @(negedge clk);
    check("R10", "rsp valid held", 32'(cpu_rsp_valid), 32'd1);
    check("R10", "rsp data held", cpu_rsp_data, held);
    check("R10", "no accept while pending", 32'(cpu_req_ready), 32'd0);
    check("R10", "data under pressure", held, memf(ad(3, 0, 0, 1)));
    cpu_req_valid = 1'b0;
    cpu_rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", "no extra reads", 32'(rd_tot - rd0), 32'd0);

    // R1: reset empties the cache
    do_reset();
    run(1, 1'b0, ad(1, 0, 0, 0), 32'h0, 4);

    // R5: replaced frame loses its other lines
    run(5, 1'b0, ad(1, 2, 0, 0), 32'h0, 4);
    run(5, 1'b0, ad(1, 2, 1, 0), 32'h0, 4);
    run(5, 1'b0, ad(2, 2, 0, 0), 32'h0, 4);
    run(5, 1'b0, ad(3, 2, 0, 0), 32'h0, 4);
    run(5, 1'b0, ad(4, 2, 0, 0), 32'h0, 4);
    run(5, 1'b0, ad(5, 2, 0, 0), 32'h0, 4);
    run(5, 1'b0, ad(5, 2, 1, 3), 32'h0, 4);
    run(5, 1'b0, ad(1, 2, 1, 0), 32'h0, 4);

    finish_run();
  end
endmodule